// File: doc/BRIEF.md
# Glitch-safe clock source sequencer

The sequencer drives the CPU clock selection of a subsystem that can run from one of four sources: a 26 MHz reference, a 32 kHz slow clock, and two high-speed on-chip oscillators. It orders the writes to the source mux and to the post-mux divider, so the core never sees the fast oscillator 1 undivided. It also steps each high-speed oscillator through its power-up and power-down controls, with fixed settling waits between the steps.

Commands come from four kinds of request pulse: a source selection, a per-oscillator turn-on, a per-oscillator turn-off, and the platform suspend and resume events. Every accepted request enters a small queue. The queue is drained one command at a time. A command is not taken until the previous one has completed all of its steps. The mux select, divider select and oscillator controls are registered outputs that feed the clock cells, which lie outside the block.

Top module: `clk_src_seq`

## Requirements
- R1: After reset the outputs are as follows: mux_sel_o = 0 (26 MHz), div2_o = 0 (divide by 1), osc1_en_o = 0, osc1_gate_o = 0, osc2_dis_o = 1, osc2_gate_o = 0 and busy_o = 0. The source encodings are 0 = 26 MHz, 1 = 32 kHz, 2 = oscillator 2 and 3 = oscillator 1.
- R2: A selection of source 3 sets div2_o on the second clock edge after the request is sampled. mux_sel_o becomes 3 on the following edge, so mux_sel_o is never 3 while div2_o is 0.
- R3: A selection of source 0, 1 or 2 changes mux_sel_o on the second clock edge after the request is sampled. div2_o clears on the following edge.
- R4: Turning on oscillator 1 (osc_on_req_i bit 0) sets osc1_en_o on the second edge after the request. osc1_gate_o is set ON_CYC cycles later, and the command completes at that point.
- R5: Turning off oscillator 1 (osc_off_req_i bit 0) clears osc1_gate_o on the second edge after the request. osc1_en_o clears OFF_CYC cycles later, and the command completes after a further OFF_CYC cycles.
- R6: Turning on oscillator 2 (bit 1) clears osc2_dis_o on the second edge after the request. osc2_gate_o is set ON_CYC cycles later, and the command completes after a further OFF_CYC cycles.
- R7: Turning off oscillator 2 (bit 1) clears osc2_gate_o on the second edge after the request. osc2_dis_o is set OFF_CYC cycles later, and the command completes after a further OFF_CYC cycles.
- R8: A suspend_i pulse acts as a selection of source 3. A resume_i pulse acts as a selection of source 2.
- R9: Requests that arrive while a command is running are queued, up to FIFO_DEPTH of them. They are executed in arrival order, and each one starts on the edge after the previous command completes.
- R10: Only one request is taken per cycle. The order of precedence is suspend, then resume, then selection, then turn-off, then turn-on, with oscillator 1 before oscillator 2. Any other request in the same cycle has no effect.
- R11: busy_o is high from the edge that samples a request until the edge on which the last queued command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_req_i | input | 1 | Source selection request pulse |
| sel_src_i | input | 2 | Requested source code |
| osc_on_req_i | input | 2 | Turn-on request pulse; bit 0 is oscillator 1, bit 1 is oscillator 2 |
| osc_off_req_i | input | 2 | Turn-off request pulse; same bit order |
| suspend_i | input | 1 | Suspend event pulse |
| resume_i | input | 1 | Resume event pulse |
| mux_sel_o | output | 2 | Clock mux select |
| div2_o | output | 1 | Divider select; 1 divides by 2 |
| osc1_en_o | output | 1 | Oscillator 1 high-clock enable |
| osc1_gate_o | output | 1 | Oscillator 1 clock gate |
| osc2_dis_o | output | 1 | Oscillator 2 disable switch |
| osc2_gate_o | output | 1 | Oscillator 2 core clock gate |
| busy_o | output | 1 | Queue not empty or a command is running |

## Verification
A stuck or misordered state machine shows up at the ports within one or two cycles of a request. The divider and the mux move on the wrong edge or in the wrong order. The second oscillator control changes one cycle early or late relative to ON_CYC or OFF_CYC. A corrupted queue appears later, as commands executed out of arrival order, or as a command that runs when it should have been dropped. That error can be seen only once the earlier command ends, which is why busy_o and the mux select are sampled across the boundary between two queued commands.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  typedef enum logic [1:0] {
    SRC_26M  = 2'd0,
    SRC_32K  = 2'd1,
    SRC_OSC2 = 2'd2,
    SRC_OSC1 = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    OP_SEL = 2'd0,
    OP_ON  = 2'd1,
    OP_OFF = 2'd2
  } op_e;

  localparam logic [1:0] ARG_OSC1 = 2'd0;
  localparam logic [1:0] ARG_OSC2 = 2'd1;

  typedef struct packed {
    op_e        op;
    logic [1:0] arg;
  } cmd_t;
endpackage

// File: rtl/clk_seq_fifo.sv
module clk_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [NW-1:0] num_q;
  logic          do_push, do_pop;

  assign valid_o = (num_q != '0);
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && ((num_q != NW'(DEPTH)) || do_pop);
  assign data_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      num_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      num_q <= num_q + 1'b1;
      else if (do_pop && !do_push) num_q <= num_q - 1'b1;
    end
  end
endmodule

// File: rtl/clk_seq_timer.sv
module clk_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (!done_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clk_seq_pkg::*;
#(
  parameter int ON_CYC  = 3900,
  parameter int OFF_CYC = 1300,
  parameter int CW      = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  cmd_t          cmd_i,
  output logic          cmd_pop_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  input  logic          tmr_done_i,
  output logic [1:0]    mux_sel_o,
  output logic          div2_o,
  output logic          osc1_en_o,
  output logic          osc1_gate_o,
  output logic          osc2_dis_o,
  output logic          osc2_gate_o,
  output logic          idle_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEL2, ST_WAIT_A, ST_WAIT_B} st_e;

  st_e  st_q;
  cmd_t cur_q;
  logic last_is_gate;

  // oscillator 1 turn-on ends with the gate, no trailing wait
  assign last_is_gate = (cur_q.op == OP_ON) && (cur_q.arg == ARG_OSC1);
  assign idle_o     = (st_q == ST_IDLE);
  assign cmd_pop_o  = idle_o && cmd_valid_i;
  assign tmr_load_o = (cmd_pop_o && cmd_i.op != OP_SEL) ||
                      (st_q == ST_WAIT_A && tmr_done_i && !last_is_gate);
  assign tmr_val_o  = (idle_o && cmd_i.op == OP_ON) ? CW'(ON_CYC - 1) : CW'(OFF_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      mux_sel_o   <= SRC_26M;
      div2_o      <= 1'b0;
      osc1_en_o   <= 1'b0;
      osc1_gate_o <= 1'b0;
      osc2_dis_o  <= 1'b1;
      osc2_gate_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          cur_q <= cmd_i;
          unique case (cmd_i.op)
            OP_SEL: begin
              if (cmd_i.arg == SRC_OSC1) div2_o <= 1'b1;
              else                       mux_sel_o <= cmd_i.arg;
              st_q <= ST_SEL2;
            end
            OP_ON: begin
              if (cmd_i.arg == ARG_OSC1) osc1_en_o  <= 1'b1;
              else                       osc2_dis_o <= 1'b0;
              st_q <= ST_WAIT_A;
            end
            default: begin
              if (cmd_i.arg == ARG_OSC1) osc1_gate_o <= 1'b0;
              else                       osc2_gate_o <= 1'b0;
              st_q <= ST_WAIT_A;
            end
          endcase
        end
        ST_SEL2: begin
          if (cur_q.arg == SRC_OSC1) mux_sel_o <= SRC_OSC1;
          else                       div2_o    <= 1'b0;
          st_q <= ST_IDLE;
        end
        ST_WAIT_A: if (tmr_done_i) begin
          if (cur_q.op == OP_ON) begin
            if (cur_q.arg == ARG_OSC1) osc1_gate_o <= 1'b1;
            else                       osc2_gate_o <= 1'b1;
          end else begin
            if (cur_q.arg == ARG_OSC1) osc1_en_o  <= 1'b0;
            else                       osc2_dis_o <= 1'b1;
          end
          st_q <= last_is_gate ? ST_IDLE : ST_WAIT_B;
        end
        default: if (tmr_done_i) st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
  import clk_seq_pkg::*;
#(
  parameter int ON_CYC     = 3900,
  parameter int OFF_CYC    = 1300,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_req_i,
  input  logic [1:0] sel_src_i,
  input  logic [1:0] osc_on_req_i,
  input  logic [1:0] osc_off_req_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  output logic [1:0] mux_sel_o,
  output logic       div2_o,
  output logic       osc1_en_o,
  output logic       osc1_gate_o,
  output logic       osc2_dis_o,
  output logic       osc2_gate_o,
  output logic       busy_o
);
  localparam int MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int CMDW = $bits(cmd_t);

  cmd_t          in_cmd, head_cmd;
  logic          in_push, head_valid, pop;
  logic          tmr_load, tmr_done, idle;
  logic [CW-1:0] tmr_val;
  logic [CMDW-1:0] head_raw;

  always_comb begin
    in_push = 1'b1;
    in_cmd  = '{op: OP_SEL, arg: 2'd0};
    if (suspend_i)             in_cmd = '{op: OP_SEL, arg: SRC_OSC1};
    else if (resume_i)         in_cmd = '{op: OP_SEL, arg: SRC_OSC2};
    else if (sel_req_i)        in_cmd = '{op: OP_SEL, arg: sel_src_i};
    else if (osc_off_req_i[0]) in_cmd = '{op: OP_OFF, arg: ARG_OSC1};
    else if (osc_off_req_i[1]) in_cmd = '{op: OP_OFF, arg: ARG_OSC2};
    else if (osc_on_req_i[0])  in_cmd = '{op: OP_ON,  arg: ARG_OSC1};
    else if (osc_on_req_i[1])  in_cmd = '{op: OP_ON,  arg: ARG_OSC2};
    else                       in_push = 1'b0;
  end

  clk_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(CMDW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (in_push),
    .data_i (in_cmd),
    .pop_i  (pop),
    .data_o (head_raw),
    .valid_o(head_valid)
  );
  assign head_cmd = cmd_t'(head_raw);

  clk_seq_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  clk_seq_ctrl #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_valid_i(head_valid),
    .cmd_i      (head_cmd),
    .cmd_pop_o  (pop),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_done_i (tmr_done),
    .mux_sel_o, .div2_o, .osc1_en_o, .osc1_gate_o, .osc2_dis_o, .osc2_gate_o,
    .idle_o     (idle)
  );

  assign busy_o = head_valid || !idle;
endmodule

// File: rtl/clk_src_seq_chk.sv
module clk_src_seq_chk
  import clk_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mux_sel_o,
  input logic       div2_o,
  input logic       osc1_en_o,
  input logic       osc1_gate_o,
  input logic       osc2_dis_o,
  input logic       osc2_gate_o
);
  AST_OSC1_DIVIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o == SRC_OSC1) |-> div2_o);  // R2
  AST_DIV_BEFORE_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o == SRC_OSC1 && $past(mux_sel_o) != SRC_OSC1) |-> $past(div2_o));  // R2
  AST_MUX_BEFORE_DIV1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div2_o) |-> ($past(mux_sel_o) != SRC_OSC1));  // R3
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mux_sel_o != $past(mux_sel_o), div2_o != $past(div2_o),
                osc1_en_o != $past(osc1_en_o), osc1_gate_o != $past(osc1_gate_o),
                osc2_dis_o != $past(osc2_dis_o), osc2_gate_o != $past(osc2_gate_o)}) <= 1);  // R10
  AST_OSC1_GATE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc1_gate_o |-> osc1_en_o);  // R4
  AST_OSC1_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc1_en_o) |-> !$past(osc1_gate_o));  // R5
  AST_OSC2_GATE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc2_gate_o |-> !osc2_dis_o);  // R6
  AST_OSC2_DIS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc2_dis_o) |-> !$past(osc2_gate_o));  // R7
endmodule

bind clk_src_seq clk_src_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mux_sel_o(mux_sel_o), .div2_o(div2_o),
  .osc1_en_o(osc1_en_o), .osc1_gate_o(osc1_gate_o),
  .osc2_dis_o(osc2_dis_o), .osc2_gate_o(osc2_gate_o)
);

// File: tb/sim_clk_src_seq.sv
`timescale 1ns/1ps
module sim_clk_src_seq;
  localparam int ON  = 12;
  localparam int OFF = 5;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sel_req_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0;
  logic [1:0] sel_src_i = 2'd0, osc_on_req_i = 2'd0, osc_off_req_i = 2'd0;
  logic [1:0] mux_sel_o;
  logic       div2_o, osc1_en_o, osc1_gate_o, osc2_dis_o, osc2_gate_o, busy_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  clk_src_seq #(.ON_CYC(ON), .OFF_CYC(OFF), .FIFO_DEPTH(4)) u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // each pulse leaves the bench just after the sampling edge
  task automatic pulse_sel(logic [1:0] src);
    @(negedge clk_i); sel_req_i = 1'b1; sel_src_i = src;
    @(negedge clk_i); sel_req_i = 1'b0;
  endtask

  task automatic pulse_on(logic [1:0] m);
    @(negedge clk_i); osc_on_req_i = m;
    @(negedge clk_i); osc_on_req_i = 2'd0;
  endtask

  task automatic pulse_off(logic [1:0] m);
    @(negedge clk_i); osc_off_req_i = m;
    @(negedge clk_i); osc_off_req_i = 2'd0;
  endtask

  task automatic t_reset;
    chk("R1 mux", mux_sel_o, 0);       chk("R1 div", div2_o, 0);
    chk("R1 en1", osc1_en_o, 0);       chk("R1 gate1", osc1_gate_o, 0);
    chk("R1 dis2", osc2_dis_o, 1);     chk("R1 gate2", osc2_gate_o, 0);
    chk("R1 busy", busy_o, 0);
  endtask

  task automatic t_sel_osc1;
    pulse_sel(2'd3);
    chk("R11 busy on request", busy_o, 1);
    chk("R2 mux held", mux_sel_o, 0);
    step(1); chk("R2 div first", div2_o, 1); chk("R2 mux not yet", mux_sel_o, 0);
    step(1); chk("R2 mux osc1", mux_sel_o, 3); chk("R11 busy done", busy_o, 0);
  endtask

  task automatic t_sel_slow;
    pulse_sel(2'd1);
    step(1); chk("R3 mux first", mux_sel_o, 1); chk("R3 div held", div2_o, 1);
    step(1); chk("R3 div cleared", div2_o, 0); chk("R11 busy done", busy_o, 0);
  endtask

  task automatic t_osc1_on;
    pulse_on(2'b01);
    step(1); chk("R4 en", osc1_en_o, 1); chk("R4 gate off", osc1_gate_o, 0);
    step(ON - 1); chk("R4 gate early", osc1_gate_o, 0); chk("R11 busy wait", busy_o, 1);
    step(1); chk("R4 gate on", osc1_gate_o, 1); chk("R4 done", busy_o, 0);
  endtask

  task automatic t_osc1_off;
    pulse_off(2'b01);
    step(1); chk("R5 gate off", osc1_gate_o, 0); chk("R5 en held", osc1_en_o, 1);
    step(OFF - 1); chk("R5 en early", osc1_en_o, 1);
    step(1); chk("R5 en off", osc1_en_o, 0); chk("R5 busy tail", busy_o, 1);
    step(OFF - 1); chk("R5 busy tail end", busy_o, 1);
    step(1); chk("R5 done", busy_o, 0);
  endtask

  task automatic t_osc2_on;
    pulse_on(2'b10);
    step(1); chk("R6 dis clear", osc2_dis_o, 0); chk("R6 gate off", osc2_gate_o, 0);
    step(ON - 1); chk("R6 gate early", osc2_gate_o, 0);
    step(1); chk("R6 gate on", osc2_gate_o, 1); chk("R6 busy tail", busy_o, 1);
    step(OFF - 1); chk("R6 busy tail end", busy_o, 1);
    step(1); chk("R6 done", busy_o, 0);
  endtask

  task automatic t_osc2_off;
    pulse_off(2'b10);
    step(1); chk("R7 gate off", osc2_gate_o, 0); chk("R7 dis held", osc2_dis_o, 0);
    step(OFF - 1); chk("R7 dis early", osc2_dis_o, 0);
    step(1); chk("R7 dis set", osc2_dis_o, 1); chk("R7 busy tail", busy_o, 1);
    step(OFF); chk("R7 done", busy_o, 0);
  endtask

  task automatic t_events;
    @(negedge clk_i); suspend_i = 1'b1;
    @(negedge clk_i); suspend_i = 1'b0;
    step(1); chk("R8 suspend div", div2_o, 1); chk("R8 suspend mux held", mux_sel_o, 1);
    step(1); chk("R8 suspend mux", mux_sel_o, 3);
    @(negedge clk_i); resume_i = 1'b1;
    @(negedge clk_i); resume_i = 1'b0;
    step(1); chk("R8 resume mux", mux_sel_o, 2); chk("R8 resume div held", div2_o, 1);
    step(1); chk("R8 resume div", div2_o, 0);
  endtask

  task automatic t_queue;
    @(negedge clk_i); osc_on_req_i = 2'b10;
    @(negedge clk_i); osc_on_req_i = 2'b00; sel_req_i = 1'b1; sel_src_i = 2'd1;
    @(negedge clk_i); sel_req_i = 1'b0;
    chk("R9 first runs", osc2_dis_o, 0);
    step(ON + OFF);
    chk("R9 second waits", mux_sel_o, 2); chk("R9 gate2", osc2_gate_o, 1);
    chk("R11 busy queued", busy_o, 1);
    step(1); chk("R9 second runs", mux_sel_o, 1);
    step(1); chk("R9 div", div2_o, 0); chk("R11 queue drained", busy_o, 0);
  endtask

  task automatic t_priority;
    @(negedge clk_i); sel_req_i = 1'b1; sel_src_i = 2'd0; osc_on_req_i = 2'b01;
    @(negedge clk_i); sel_req_i = 1'b0; osc_on_req_i = 2'b00;
    step(2); chk("R10 select wins", mux_sel_o, 0);
    step(ON + 3);
    chk("R10 on ignored en", osc1_en_o, 0); chk("R10 on ignored gate", osc1_gate_o, 0);
    chk("R10 idle", busy_o, 0);
    @(negedge clk_i); suspend_i = 1'b1; resume_i = 1'b1;
    @(negedge clk_i); suspend_i = 1'b0; resume_i = 1'b0;
    step(2); chk("R10 suspend wins", mux_sel_o, 3);
    step(3); chk("R10 resume ignored", mux_sel_o, 3); chk("R10 idle 2", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_sel_osc1();
    t_sel_slow();
    t_osc1_on();
    t_osc1_off();
    t_osc2_on();
    t_osc2_off();
    t_events();
    t_queue();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule